// File: doc/BRIEF.md
# EV Charging Pilot Controller

This block drives the control-pilot line of an electric-vehicle charging station and works out what the attached vehicle is asking for. When no vehicle is present it holds the line at the positive rail. Once a vehicle is seen, it runs a 1 ms square wave. The high time of that wave, set in tenths of a percent, advertises the current the station can supply. Two duty settings are held, one for each charging mode (L1, L2), and a mode input picks the one in use. In an error it parks the line at the negative rail.

The same line is read back through an external ADC. The block chooses when a reading is taken. A high-side reading is taken a settling delay after each rising edge, and a low-side reading a settling delay after each falling edge. The high-side reading is compared against four programmable thresholds to give a raw state. That raw state becomes the reported state only after it has been seen on several high-side readings in a row. A low-side reading that fails to get down near the negative rail means the vehicle's diode is missing. That condition is latched and forces the error state until the vehicle is unplugged (state A accepted) or the block is reset.

Top module: `evse_pilot_ctrl`

## Requirements
- R1: After reset the state output is A (code 0), the diode flag is 0 and the pilot is held steadily high: every cycle of a full PWM period shows `pilot_hi`=1 while the state is A.
- R2: In state E (code 4) or F (code 5) `pilot_hi` is 0 on every cycle. Asserting `fault_req` gives state F in the same cycle; releasing it restores the debounced state.
- R3: In states B, C and D (codes 1, 2, 3) the pilot repeats every CLK_HZ/1000 cycles. It is high for duty·period/1000 cycles of each period, with the duty clamped to 1000, and the duty is taken up at the start of a period.
- R4: `mode_l2`=0 selects `duty_l1` and `mode_l2`=1 selects `duty_l2` as the active duty.
- R5: A high-side reading v decodes to A when v ≥ `thr_ab`, else B when v ≥ `thr_bc`, else C when v ≥ `thr_cd`, else D when v ≥ `thr_de`, else E.
- R6: A decoded value becomes the reported state only after DEBOUNCE consecutive high-side readings give that same value; any differing reading restarts the count.
- R7: A low-side reading greater than `thr_neg` sets `diode_fault`. While the flag is set, the state is F, `pwm_active` is 0 and `pilot_hi` is 0.
- R8: `diode_fault` stays set through readings of other states. It clears only on reset or when state A is accepted by the debounce.
- R9: `smp_hi` pulses SETTLE cycles after the pilot rises, and `smp_lo` pulses SETTLE cycles after it falls. No high-side reading is taken in PWM when the high time is SETTLE cycles or less. Outside PWM, one high-side reading is taken per period, at SETTLE cycles into it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_l2 | input | 1 | Charging mode select, 1 = L2 duty |
| duty_l1 | input | 10 | L1 duty in 0.1 % steps |
| duty_l2 | input | 10 | L2 duty in 0.1 % steps |
| fault_req | input | 1 | External error request, forces state F |
| adc_data | input | AW | Current ADC reading of the pilot line |
| thr_ab | input | AW | Lower bound of the A band |
| thr_bc | input | AW | Lower bound of the B band |
| thr_cd | input | AW | Lower bound of the C band |
| thr_de | input | AW | Lower bound of the D band |
| thr_neg | input | AW | Highest low-side reading accepted as a present diode |
| pilot_hi | output | 1 | Pilot drive, 1 = positive rail, 0 = negative rail |
| pwm_active | output | 1 | Pilot is running as a square wave |
| smp_hi | output | 1 | High-side reading is captured at the next edge |
| smp_lo | output | 1 | Low-side reading is captured at the next edge |
| state | output | 3 | Reported state: A=0, B=1, C=2, D=3, E=4, F=5 |
| diode_fault | output | 1 | Latched missing-diode flag |

## Verification
The bench builds the block with CLK_HZ = 100000, SETTLE = 5 and DEBOUNCE = 3. A PWM period is then 100 cycles, each 1 % of duty is exactly one cycle, and a full debounce takes three periods. At these values the high-time counts, the clamp at 100 %, the settle offsets and the too-short high time (3 cycles against a settle of 5) can each be checked cycle by cycle. The bench models the line as one reading while driven high and another while driven low, so a missing diode is produced by raising the low-side level.

// File: rtl/evse_pilot_ctrl.sv
module evse_pilot_ctrl #(
  parameter int CLK_HZ   = 50_000_000,
  parameter int AW       = 10,
  parameter int SETTLE   = 500,
  parameter int DEBOUNCE = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_l2,
  input  logic [9:0]    duty_l1,
  input  logic [9:0]    duty_l2,
  input  logic          fault_req,
  input  logic [AW-1:0] adc_data,
  input  logic [AW-1:0] thr_ab,
  input  logic [AW-1:0] thr_bc,
  input  logic [AW-1:0] thr_cd,
  input  logic [AW-1:0] thr_de,
  input  logic [AW-1:0] thr_neg,
  output logic          pilot_hi,
  output logic          pwm_active,
  output logic          smp_hi,
  output logic          smp_lo,
  output logic [2:0]    state,
  output logic          diode_fault
);
  localparam int PER = CLK_HZ / 1000;
  localparam int LW  = $clog2(PER + 1);
  localparam int CW  = $clog2(DEBOUNCE + 1);
  localparam int DW  = 10;
  localparam int MW  = DW + LW;

  localparam logic [2:0] ST_A = 3'd0, ST_B = 3'd1, ST_C = 3'd2,
                         ST_D = 3'd3, ST_E = 3'd4, ST_F = 3'd5;

  logic [LW-1:0] ph, hi_len;
  logic [2:0]    cand, stab, raw;
  logic [CW-1:0] cnt, n_cnt;
  logic          diode_q;

  wire [DW-1:0] duty_sel = mode_l2 ? duty_l2 : duty_l1;
  wire [DW-1:0] duty_c   = (duty_sel > DW'(1000)) ? DW'(1000) : duty_sel;
  wire [MW-1:0] prod     = MW'(duty_c) * MW'(PER);
  wire [MW-1:0] len_n    = prod / MW'(1000);
  wire          wrap     = (ph == LW'(PER - 1));
  wire [LW:0]   lo_at    = {1'b0, hi_len} + (LW+1)'(SETTLE);

  assign state       = (fault_req || diode_q) ? ST_F : stab;
  assign diode_fault = diode_q;
  assign pwm_active  = (state == ST_B) || (state == ST_C) || (state == ST_D);
  assign pilot_hi    = (state == ST_A) || (pwm_active && (ph < hi_len));
  assign smp_hi      = (ph == LW'(SETTLE)) && (!pwm_active || (hi_len > LW'(SETTLE)));
  assign smp_lo      = pwm_active && (lo_at < (LW+1)'(PER)) && ({1'b0, ph} == lo_at);

  always_comb begin
    if      (adc_data >= thr_ab) raw = ST_A;
    else if (adc_data >= thr_bc) raw = ST_B;
    else if (adc_data >= thr_cd) raw = ST_C;
    else if (adc_data >= thr_de) raw = ST_D;
    else                         raw = ST_E;
  end

  always_comb begin
    if (raw != cand)                 n_cnt = CW'(1);
    else if (cnt == CW'(DEBOUNCE))   n_cnt = cnt;
    else                             n_cnt = cnt + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= '0;
      hi_len <= '0;
    end else begin
      ph <= wrap ? '0 : ph + LW'(1);
      if (wrap) hi_len <= len_n[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cand <= ST_A;
      cnt  <= '0;
      stab <= ST_A;
    end else if (smp_hi) begin
      cand <= raw;
      cnt  <= n_cnt;
      if (n_cnt == CW'(DEBOUNCE)) stab <= raw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      diode_q <= 1'b0;
    else if (smp_lo && (adc_data > thr_neg))
      diode_q <= 1'b1;
    else if (smp_hi && (n_cnt == CW'(DEBOUNCE)) && (raw == ST_A))
      diode_q <= 1'b0;
  end
endmodule

// File: rtl/evse_pilot_chk.sv
module evse_pilot_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_req,
  input logic       pilot_hi,
  input logic       pwm_active,
  input logic       smp_hi,
  input logic       smp_lo,
  input logic [2:0] state,
  input logic       diode_fault
);
  p_steady_hi_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 3'd0) |-> pilot_hi);

  p_err_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == 3'd4) || (state == 3'd5)) |-> !pilot_hi);

  p_fault_f_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_req |-> (state == 3'd5));

  p_diode_forces_r7: assert property (@(posedge clk) disable iff (!rst_n)
    diode_fault |-> ((state == 3'd5) && !pwm_active && !pilot_hi));

  p_diode_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(diode_fault) |-> ((state == 3'd0) || fault_req));

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({smp_hi, smp_lo}));

  p_hi_sample_in_pwm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_hi && pwm_active) |-> pilot_hi);

  p_lo_sample_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    smp_lo |-> (!pilot_hi && pwm_active));
endmodule

bind evse_pilot_ctrl evse_pilot_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault_req(fault_req), .pilot_hi(pilot_hi),
  .pwm_active(pwm_active), .smp_hi(smp_hi), .smp_lo(smp_lo),
  .state(state), .diode_fault(diode_fault)
);

// File: tb/test_evse_pilot_ctrl.sv
module test_evse_pilot_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int PER = 100;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_l2, fault_req;
  logic [9:0] duty_l1, duty_l2;
  logic [9:0] hi_level, lo_level;
  wire  [9:0] adc_data;
  wire        pilot_hi, pwm_active, smp_hi, smp_lo, diode_fault;
  wire  [2:0] state;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign adc_data = pilot_hi ? hi_level : lo_level;

  evse_pilot_ctrl #(.CLK_HZ(100_000), .AW(10), .SETTLE(5), .DEBOUNCE(3)) i_evse_pilot_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_l2(mode_l2), .duty_l1(duty_l1), .duty_l2(duty_l2),
    .fault_req(fault_req), .adc_data(adc_data),
    .thr_ab(10'd900), .thr_bc(10'd750), .thr_cd(10'd600), .thr_de(10'd450), .thr_neg(10'd100),
    .pilot_hi(pilot_hi), .pwm_active(pwm_active), .smp_hi(smp_hi), .smp_lo(smp_lo),
    .state(state), .diode_fault(diode_fault));

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; mode_l2 = 1'b0; fault_req = 1'b0;
    duty_l1 = 10'd250; duty_l2 = 10'd600;
    hi_level = 10'd1000; lo_level = 10'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_hi(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!smp_hi) @(negedge clk);
    end
    @(negedge clk);
  endtask

  task automatic wait_lo();
    @(negedge clk);
    while (!smp_lo) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic count_high(output int c);
    c = 0;
    for (int i = 0; i < PER; i++) begin
      @(negedge clk);
      if (pilot_hi) c++;
    end
  endtask

  task automatic t_idle();
    int c;
    do_reset();
    chk("R1 reset state", state, 0);
    chk("R1 reset diode", diode_fault, 0);
    chk("R1 reset pwm", pwm_active, 0);
    count_high(c);
    chk("R1 steady high count", c, PER);
  endtask

  task automatic t_pwm();
    int c;
    do_reset();
    hi_level = 10'd820;
    wait_hi(2);
    chk("R6 not yet accepted", state, 0);
    wait_hi(1);
    chk("R5 R6 state B", state, 1);
    repeat (2*PER) @(negedge clk);
    count_high(c);
    chk("R3 duty 25.0%", c, 25);
    mode_l2 = 1'b1;
    repeat (2*PER) @(negedge clk);
    count_high(c);
    chk("R4 L2 duty 60.0%", c, 60);
    duty_l2 = 10'd1023;
    repeat (2*PER) @(negedge clk);
    count_high(c);
    chk("R3 duty clamp", c, PER);
    duty_l2 = 10'd0;
    repeat (2*PER) @(negedge clk);
    count_high(c);
    chk("R3 duty zero", c, 0);
    chk("R3 still B", state, 1);
  endtask

  task automatic t_glitch();
    do_reset();
    hi_level = 10'd820;
    wait_hi(2);
    hi_level = 10'd1000;
    wait_hi(1);
    hi_level = 10'd820;
    wait_hi(2);
    chk("R6 restarted count", state, 0);
    wait_hi(1);
    chk("R6 accepted after 3", state, 1);
  endtask

  task automatic t_bands();
    int c;
    do_reset();
    hi_level = 10'd680;
    wait_hi(3);
    chk("R5 state C", state, 2);
    hi_level = 10'd530;
    wait_hi(3);
    chk("R5 state D", state, 3);
    hi_level = 10'd300;
    wait_hi(3);
    chk("R5 state E", state, 4);
    count_high(c);
    chk("R2 E steady low", c, 0);
  endtask

  task automatic t_fault();
    int c;
    do_reset();
    fault_req = 1'b1;
    @(negedge clk);
    chk("R2 fault gives F", state, 5);
    count_high(c);
    chk("R2 F steady low", c, 0);
    fault_req = 1'b0;
    @(negedge clk);
    chk("R2 fault release", state, 0);
    chk("R2 fault release pilot", pilot_hi, 1);
  endtask

  task automatic t_diode();
    int c;
    do_reset();
    hi_level = 10'd820;
    wait_hi(3);
    chk("R7 pre state B", state, 1);
    lo_level = 10'd300;
    wait_lo();
    chk("R7 diode flag", diode_fault, 1);
    chk("R7 state F", state, 5);
    chk("R7 pwm off", pwm_active, 0);
    count_high(c);
    chk("R7 steady low", c, 0);
    wait_hi(4);
    chk("R8 flag held", diode_fault, 1);
    chk("R8 state held F", state, 5);
    hi_level = 10'd1000; lo_level = 10'd1000;
    wait_hi(2);
    chk("R8 not cleared early", diode_fault, 1);
    wait_hi(1);
    chk("R8 cleared by A", diode_fault, 0);
    chk("R8 state A", state, 0);
    chk("R8 pilot high", pilot_hi, 1);
  endtask

  task automatic t_timing();
    int d, n;
    logic prev;
    do_reset();
    hi_level = 10'd820;
    wait_hi(3);
    repeat (2*PER) @(negedge clk);
    prev = pilot_hi;
    @(negedge clk);
    while (!(pilot_hi && !prev)) begin prev = pilot_hi; @(negedge clk); end
    d = 0;
    while (!smp_hi && d < PER) begin @(negedge clk); d++; end
    chk("R9 rise to smp_hi", d, 5);
    prev = pilot_hi;
    @(negedge clk);
    while (!(!pilot_hi && prev)) begin prev = pilot_hi; @(negedge clk); end
    d = 0;
    while (!smp_lo && d < PER) begin @(negedge clk); d++; end
    chk("R9 fall to smp_lo", d, 5);
    duty_l1 = 10'd30;
    repeat (2*PER) @(negedge clk);
    n = 0;
    for (int i = 0; i < 2*PER; i++) begin
      @(negedge clk);
      if (smp_hi) n++;
    end
    chk("R9 no hi sample short high", n, 0);
    chk("R9 state kept", state, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_idle();
    t_pwm();
    t_glitch();
    t_bands();
    t_fault();
    t_diode();
    t_timing();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule